// File: doc/BRIEF.md
# Validating Receive FIFO for a USB OUT Endpoint

This block is the byte store between the USB receive engine and the CPU for one host-to-device endpoint. The engine marks the start of each packet and delivers its bytes one per clock. It then closes the packet with an end strobe and a good/bad verdict from its own error checks. Bytes are written into the store as they arrive, but the CPU cannot see them until the verdict is good. A bad verdict throws the whole packet away, and the store is left exactly as it was before that packet began.

On the CPU side there is a byte-wide read port, a count of the bytes that can be read, and two sticky flags. The packet flag rises for every accepted packet. The transfer flag rises when an accepted packet is shorter than the maximum packet size, which includes a packet with no data. While the transfer flag is set, the block tells the engine to NAK, so the next transfer cannot mix with unread data. Software may drop the transfer flag only after it has read the count. The block also asks for NAK whenever the free space is smaller than one maximum-size packet, so a packet is never partly stored.

Top module: `oep_out_fifo`

## Requirements
- R1: Bytes of a packet in reception do not change `byte_count` or become readable until the packet's end strobe arrives with `rx_good` high.
- R2: A good end strobe adds the packet length to `byte_count` on the following clock edge, and the bytes read out in the order they arrived.
- R3: A bad end strobe (`rx_good` low) leaves `byte_count` and the stored readable data unchanged, and the packet's bytes are never read.
- R4: `pkt_flag` is set on the edge that commits a good packet and stays set until `pkt_clr`; when a commit and `pkt_clr` fall in the same cycle, the flag stays set.
- R5: `xfer_flag` is set on the edge that commits a good packet with fewer than MAXPKT bytes, zero bytes included; a packet of exactly MAXPKT bytes does not set it.
- R6: While `xfer_flag` is high, `rx_nak` is high, and a packet whose `rx_start` falls in that time is ignored: its bytes and end strobe leave `byte_count` and the flags unchanged.
- R7: `xfer_clr` clears `xfer_flag` only when `count_rd` was asserted in an earlier cycle while the flag was set; without that, `xfer_clr` has no effect.
- R8: `rx_nak` is high whenever DEPTH minus `byte_count` is less than MAXPKT, and a packet started under NAK is ignored as in R6.
- R9: A read (`rd_en`) while `byte_count` is zero returns 0 on `rd_data` and leaves `byte_count` unchanged.
- R10: Bytes after the first MAXPKT of a packet are dropped; such a packet, if good, commits MAXPKT bytes.
- R11: `rd_data` shows the oldest readable byte on the edge after the cycle `rd_en` is high, `byte_count` drops by one on that same edge, and `rd_data` holds its value when `rd_en` is low.
- R12: After reset, `byte_count` is 0, both flags are low, `rd_data` is 0, and `rx_nak` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_start | input | 1 | Start of an incoming packet |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | DW | Incoming byte |
| rx_end | input | 1 | End of packet strobe |
| rx_good | input | 1 | Packet passed error checks (sampled with rx_end) |
| rx_nak | output | 1 | Ask the engine to NAK the next packet |
| rd_en | input | 1 | CPU pops one byte |
| rd_data | output | DW | Byte returned by the last pop |
| byte_count | output | AW+1 | Readable bytes |
| count_rd | input | 1 | CPU read the count register |
| pkt_flag | output | 1 | Packet accepted flag |
| pkt_clr | input | 1 | Clear pkt_flag |
| xfer_flag | output | 1 | Transfer complete flag |
| xfer_clr | input | 1 | Request to clear xfer_flag |

## Verification
Every result is due exactly one edge after the cycle that causes it. A good end strobe updates `byte_count`, `pkt_flag` and `xfer_flag` on the next edge. A pop updates `rd_data` and `byte_count` on the next edge. `rx_nak` follows the registered count and flag in the same cycle, with no added delay. The bench drives its inputs just after a falling edge. A behavioural queue model takes those same inputs at the rising edge. Every output is compared at the following falling edge, so each check samples one edge after its stimulus, and a late or early update shows up as a miscompare.

// File: rtl/oep_pkg.sv
// Shared types for the OUT endpoint FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package oep_pkg;
    // Commit event produced by the receive side in the cycle of a good end strobe.
    typedef struct packed {
        logic fire;       // a good packet is committed on this edge
        logic short_pkt;  // its length is below the maximum packet size
    } commit_t;
endpackage

// File: rtl/oep_store.sv
// Byte storage: one synchronous write port, one asynchronous read port.
// Assumes: the reader never addresses a location outside the committed region,
// so the contents need no reset.
module oep_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write one received byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/oep_rx_ctrl.sv
// Receive side: stages packet bytes behind a speculative pointer and commits or
// rewinds it on the end strobe. Produces NAK for lock or low space.
// Assumes: rx_start, rx_valid and rx_end are never high in the same cycle
// (rx_start wins, then rx_valid); pointers carry one wrap bit.
module oep_rx_ctrl
    import oep_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 32,
    parameter int MAXPKT = 8,
    parameter int AW     = $clog2(DEPTH),
    parameter int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_start,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_good,
    input  logic [PW-1:0] rd_ptr,
    input  logic          eot_flag,
    output logic          nak,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [PW-1:0] com_ptr,
    output commit_t       commit
);
    localparam int LW = $clog2(MAXPKT + 1);
    localparam logic [LW-1:0] LEN_MAX = LW'(MAXPKT);
    localparam logic [PW:0]   MAX_W   = (PW+1)'(MAXPKT);
    localparam logic [PW:0]   DEPTH_W = (PW+1)'(DEPTH);

    logic [PW-1:0] spec_ptr;
    logic [PW-1:0] com_q;
    logic [LW-1:0] len;
    logic          active;
    logic [PW-1:0] used;
    logic          space_low;
    logic          end_now;

    // Low-space test: would a full packet exceed the free room?
    always_comb begin
        used      = com_q - rd_ptr;
        space_low = ({1'b0, used} + MAX_W) > DEPTH_W;
    end

    assign nak     = eot_flag | space_low;
    assign we      = active & rx_valid & ~rx_start & (len != LEN_MAX);
    assign waddr   = spec_ptr[AW-1:0];
    assign wdata   = rx_data;
    assign com_ptr = com_q;
    assign end_now = active & rx_end & ~rx_start & ~rx_valid;
    assign commit.fire      = end_now & rx_good;
    assign commit.short_pkt = len != LEN_MAX;

    // Track packet acceptance, staging pointer, length and commit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            spec_ptr <= '0;
            com_q    <= '0;
            len      <= '0;
        end else if (rx_start) begin
            active   <= ~nak;
            spec_ptr <= com_q;
            len      <= '0;
        end else if (we) begin
            spec_ptr <= spec_ptr + 1'b1;
            len      <= len + 1'b1;
        end else if (end_now) begin
            active <= 1'b0;
            len    <= '0;
            if (rx_good) com_q    <= spec_ptr;
            else         spec_ptr <= com_q;
        end
    end
endmodule

// File: rtl/oep_rd_port.sv
// CPU read side: pops committed bytes one per request and reports the count.
// Assumes: com_ptr only moves forward and never passes rd_ptr by more than DEPTH.
module oep_rd_port #(
    parameter int DW = 8,
    parameter int AW = 5,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] com_ptr,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] count,
    output logic [DW-1:0] rd_data
);
    assign count = com_ptr - rd_ptr;
    assign raddr = rd_ptr[AW-1:0];

    // Pop a byte, or return zero from an empty region without moving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            if (count != '0) begin
                rd_data <= mem_q;
                rd_ptr  <= rd_ptr + 1'b1;
            end else begin
                rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/oep_flags.sv
// Packet and transfer completion flags with the count-read clear interlock.
// Assumes: a commit cannot arrive while the transfer flag is set (NAK holds it off).
module oep_flags
    import oep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  commit_t commit,
    input  logic    pkt_clr,
    input  logic    count_rd,
    input  logic    xfer_clr,
    output logic    pkt_flag,
    output logic    xfer_flag
);
    logic armed;

    // Packet flag: set by a commit, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_flag <= 1'b0;
        else        pkt_flag <= commit.fire | (pkt_flag & ~pkt_clr);
    end

    // Transfer flag: set by a short commit, cleared only after a count read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_flag <= 1'b0;
            armed     <= 1'b0;
        end else if (commit.fire && commit.short_pkt) begin
            xfer_flag <= 1'b1;
            armed     <= 1'b0;
        end else if (xfer_flag && xfer_clr && armed) begin
            xfer_flag <= 1'b0;
            armed     <= 1'b0;
        end else if (xfer_flag && count_rd) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/oep_out_fifo.sv
// Top of the OUT endpoint FIFO: storage, receive staging, CPU read port and flags.
// Assumes: one packet in flight at a time; the engine samples rx_nak when it
// decides whether to start a packet.
module oep_out_fifo
    import oep_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 32,
    parameter int MAXPKT = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_start,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_good,
    output logic          rx_nak,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [AW:0]   byte_count,
    input  logic          count_rd,
    output logic          pkt_flag,
    input  logic          pkt_clr,
    output logic          xfer_flag,
    input  logic          xfer_clr
);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_q;
    logic [PW-1:0] com_ptr;
    logic [PW-1:0] rd_ptr;
    commit_t       commit;

    oep_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_q)
    );

    oep_rx_ctrl #(.DW(DW), .DEPTH(DEPTH), .MAXPKT(MAXPKT), .AW(AW), .PW(PW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_good(rx_good), .rd_ptr(rd_ptr),
        .eot_flag(xfer_flag), .nak(rx_nak), .we(we), .waddr(waddr),
        .wdata(wdata), .com_ptr(com_ptr), .commit(commit)
    );

    oep_rd_port #(.DW(DW), .AW(AW), .PW(PW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .com_ptr(com_ptr),
        .mem_q(mem_q), .raddr(raddr), .rd_ptr(rd_ptr), .count(byte_count),
        .rd_data(rd_data)
    );

    oep_flags u_flags (
        .clk(clk), .rst_n(rst_n), .commit(commit), .pkt_clr(pkt_clr),
        .count_rd(count_rd), .xfer_clr(xfer_clr), .pkt_flag(pkt_flag),
        .xfer_flag(xfer_flag)
    );
endmodule

// File: rtl/oep_fifo_chk.sv
// Checker for oep_out_fifo, attached by bind; observes ports only.
// Assumes: the engine never raises rx_end together with rx_start or rx_valid.
module oep_fifo_chk #(
    parameter int DW     = 8,
    parameter int DEPTH  = 32,
    parameter int MAXPKT = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_start,
    input logic          rx_valid,
    input logic [DW-1:0] rx_data,
    input logic          rx_end,
    input logic          rx_good,
    input logic          rx_nak,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   byte_count,
    input logic          count_rd,
    input logic          pkt_flag,
    input logic          pkt_clr,
    input logic          xfer_flag,
    input logic          xfer_clr
);
    AST_HIDDEN_UNTIL_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count > $past(byte_count)) |-> $past(rx_end && rx_good)); // R1
    AST_BAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_end && !rx_good && !rd_en) |-> byte_count == $past(byte_count)); // R3
    AST_PKT_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_flag) |-> $past(rx_end && rx_good)); // R4
    AST_XFER_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_flag) |-> $past(rx_end && rx_good)); // R5
    AST_LOCK_FORCES_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_flag |-> rx_nak); // R6
    AST_XFER_CLEARED_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_flag) |-> $past(xfer_clr)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= (AW+1)'(DEPTH)); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && byte_count == '0) |-> (rd_data == '0 && byte_count == $past(byte_count))); // R9
endmodule

bind oep_out_fifo oep_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .MAXPKT(MAXPKT), .AW(AW)) u_chk (.*);

// File: tb/oep_out_fifo_tb.sv
`timescale 1ns/1ps
// Bench: a queue-based reference model updated at each rising edge and compared
// with every output at each falling edge.
module oep_out_fifo_tb;
    localparam int DW = 8, DEPTH = 32, MAXPKT = 8, AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_start = 0, rx_valid = 0, rx_end = 0, rx_good = 0;
    logic [DW-1:0] rx_data = '0;
    logic rd_en = 0, count_rd = 0, pkt_clr = 0, xfer_clr = 0;
    logic rx_nak, pkt_flag, xfer_flag;
    logic [DW-1:0] rd_data;
    logic [AW:0] byte_count;

    int vectors = 0, fails = 0;
    logic [DW-1:0] seed = 8'h10;

    // reference model state
    logic [DW-1:0] mq[$];
    logic [DW-1:0] stg[$];
    bit m_act, m_eop, m_eot, m_arm;
    logic [DW-1:0] m_rd;

    always #4 clk = ~clk;

    oep_out_fifo #(.DW(DW), .DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_good(rx_good), .rx_nak(rx_nak),
        .rd_en(rd_en), .rd_data(rd_data), .byte_count(byte_count),
        .count_rd(count_rd), .pkt_flag(pkt_flag), .pkt_clr(pkt_clr),
        .xfer_flag(xfer_flag), .xfer_clr(xfer_clr)
    );

    function automatic bit m_nak();
        return m_eot || ((DEPTH - mq.size()) < MAXPKT);
    endfunction

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); stg.delete();
            m_act = 0; m_eop = 0; m_eot = 0; m_arm = 0; m_rd = '0;
        end else begin
            bit nk, c_fire, c_short;
            nk = m_nak(); c_fire = 0; c_short = 0;
            if (rd_en) begin
                if (mq.size() > 0) m_rd = mq.pop_front();
                else m_rd = '0;
            end
            if (rx_start) begin
                m_act = !nk; stg.delete();
            end else if (m_act && rx_valid) begin
                if (stg.size() < MAXPKT) stg.push_back(rx_data);
            end else if (m_act && rx_end) begin
                m_act = 0;
                if (rx_good) begin
                    c_fire = 1; c_short = stg.size() < MAXPKT;
                    foreach (stg[i]) mq.push_back(stg[i]);
                end
                stg.delete();
            end
            m_eop = c_fire || (m_eop && !pkt_clr);
            if (c_fire && c_short) begin m_eot = 1; m_arm = 0; end
            else if (m_eot && xfer_clr && m_arm) begin m_eot = 0; m_arm = 0; end
            else if (m_eot && count_rd) m_arm = 1;
        end
    end

    task automatic chk(string what, string req, int act, int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance one clock and compare every output at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("byte_count", "R1/R2/R3/R6/R10", int'(byte_count), mq.size());
        chk("rx_nak", "R6/R8", int'(rx_nak), int'(m_nak()));
        chk("pkt_flag", "R4", int'(pkt_flag), int'(m_eop));
        chk("xfer_flag", "R5/R7", int'(xfer_flag), int'(m_eot));
        chk("rd_data", "R9/R11", int'(rd_data), int'(m_rd));
    endtask

    task automatic send_pkt(int n, bit good, bit clr_at_end);
        rx_start = 1; tick(); rx_start = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = seed; seed = seed + 8'd1; tick();
        end
        rx_valid = 0;
        rx_end = 1; rx_good = good; pkt_clr = clr_at_end; tick();
        rx_end = 0; rx_good = 0; pkt_clr = 0;
    endtask

    task automatic pop(int n);
        for (int i = 0; i < n; i++) begin rd_en = 1; tick(); end
        rd_en = 0; tick();
    endtask

    task automatic pulse_clr();
        pkt_clr = 1; tick(); pkt_clr = 0;
    endtask

    bit done = 0;

    initial begin
        repeat (3) tick();
        // R12 reset state, checked directly
        chk("reset byte_count", "R12", int'(byte_count), 0);
        chk("reset flags", "R12", int'({pkt_flag, xfer_flag}), 0);
        chk("reset rd_data", "R12", int'(rd_data), 0);
        chk("reset rx_nak", "R12", int'(rx_nak), 0);
        rst_n = 1; tick();

        send_pkt(MAXPKT, 1, 0);          // R1 R2 full packet, no transfer end
        chk("full packet no xfer", "R5", int'(xfer_flag), 0);
        pulse_clr();
        send_pkt(5, 0, 0);               // R3 bad packet discarded
        send_pkt(MAXPKT + 2, 1, 1);      // R10 excess dropped; R4 set wins over clear
        chk("set wins", "R4", int'(pkt_flag), 1);
        pulse_clr();
        pop(2 * MAXPKT + 2);             // R11 order, R9 empty pops

        send_pkt(3, 1, 0);               // R5 short packet ends transfer
        send_pkt(4, 1, 0);               // R6 ignored while locked
        chk("locked count", "R6", int'(byte_count), 3);
        xfer_clr = 1; tick(); xfer_clr = 0; tick();          // R7 no count read yet
        chk("clear without count read", "R7", int'(xfer_flag), 1);
        count_rd = 1; xfer_clr = 1; tick(); count_rd = 0; xfer_clr = 0;
        chk("clear same cycle as count read", "R7", int'(xfer_flag), 1);
        xfer_clr = 1; tick(); xfer_clr = 0;
        chk("clear after count read", "R7", int'(xfer_flag), 0);
        pop(3);

        send_pkt(0, 1, 0);               // R5 zero-length packet
        chk("zero length ends transfer", "R5", int'(xfer_flag), 1);
        count_rd = 1; tick(); count_rd = 0; xfer_clr = 1; tick(); xfer_clr = 0;
        pulse_clr();

        for (int k = 0; k < DEPTH / MAXPKT; k++) send_pkt(MAXPKT, 1, 0);
        chk("full store nak", "R8", int'(rx_nak), 1);
        send_pkt(MAXPKT, 1, 0);          // R8 ignored under low space
        pop(1);
        chk("one free byte still nak", "R8", int'(rx_nak), 1);
        pop(MAXPKT);
        chk("room for a packet", "R8", int'(rx_nak), 0);
        send_pkt(MAXPKT, 1, 0);
        pop(DEPTH + 2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule